// File: doc/BRIEF.md
# Debug Address Match Unit

This unit watches a processor's instruction stream and data accesses against four programmable address slots. Software configures it through a small register port. Each slot has an address register. One control register holds the per-slot enables, the match kind and the watch length. A status register records which slots matched.

In every cycle the unit may see an instruction pointer, a data access or a single-step request. It compares these against every slot in the same clock. A match is recorded for each slot whose address fits, whether that slot is enabled or not. The status register is only rewritten when an enabled slot hits or a single step is requested. In that case a one-cycle debug exception pulse is raised on the following cycle.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset the four address registers and the status register read as zero, and the control register reads 0x0000_0400.
- R2: A write with `reg_sel` 0..3 stores into that address register unchanged. `reg_sel`=4 stores into status unchanged. `reg_sel`=5 stores into control with bit 10 forced to one. Other selects store nothing and read as zero. `reg_rdata` always shows the register picked by `reg_sel`.
- R3: Slot i is enabled when control bit 2i or bit 2i+1 is set.
- R4: The kind field of slot i is control bits [17+4i:16+4i]. With kind 00, slot i matches when `ip_valid` is high and its address register equals `ip`.
- R5: Kind 01 matches only data writes. Kind 11 matches data reads and writes. Kind 10 never matches.
- R6: The length field of slot i is control bits [19+4i:18+4i]. It decodes 0→1, 1→2, 2→8 and 3→4 bytes. The slot address is aligned down to that length. A data access of `dacc_size` 0..3 covers 1, 2, 4 or 8 bytes from `dacc_addr`, and it matches when that byte range overlaps the slot range.
- R7: When an enabled slot matches, status bits [3:0] are replaced by the match flags of all four slots, disabled ones included. All other status bits keep their value.
- R8: A check with no enabled match and no step request leaves status unchanged and raises no exception.
- R9: A step request replaces status bits [3:0] with the match flags, sets status bit 14 and raises the exception.
- R10: `dbg_exc` is high for exactly the one cycle after a clock edge at which an enabled match or a step request was present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0..3 address, 4 status, 5 control |
| reg_wdata | input | XLEN | Write data |
| reg_rdata | output | XLEN | Read data of the selected register |
| ip_valid | input | 1 | Instruction pointer present this cycle |
| ip | input | XLEN | Current instruction pointer |
| dacc_valid | input | 1 | Data access present this cycle |
| dacc_write | input | 1 | Data access is a write |
| dacc_addr | input | XLEN | First byte address of the data access |
| dacc_size | input | 2 | Access size code: 1, 2, 4 or 8 bytes |
| step_req | input | 1 | Single-step request |
| dbg_exc | output | 1 | Debug exception pulse |

## Verification
The assertions assume that a software write to the status register may coincide with a check. In that case the write wins, so the status-related properties are conditioned on no such write. They also assume that inputs are driven to known values from the first clock. The stimulus never writes a register in the same cycle as a check. It drives all inputs to zero before reset is released. It keeps data accesses far enough below the top of the address space that a byte range never wraps.

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_sel,
  input  logic [XLEN-1:0] reg_wdata,
  output logic [XLEN-1:0] reg_rdata,
  input  logic            ip_valid,
  input  logic [XLEN-1:0] ip,
  input  logic            dacc_valid,
  input  logic            dacc_write,
  input  logic [XLEN-1:0] dacc_addr,
  input  logic [1:0]      dacc_size,
  input  logic            step_req,
  output logic            dbg_exc
);
  localparam int NSLOT    = 4;
  localparam int KIND_LSB = 16;
  localparam int LEN_LSB  = 18;
  localparam int FIX_BIT  = 10;
  localparam int STEP_BIT = 14;
  localparam logic [2:0] SEL_STAT = 3'd4;
  localparam logic [2:0] SEL_CTRL = 3'd5;
  localparam logic [XLEN-1:0] FIX_ONES = XLEN'(1) << FIX_BIT;

  logic [XLEN-1:0] addr_q [NSLOT];
  logic [XLEN-1:0] stat_q, ctrl_q, stat_nxt;
  logic [NSLOT-1:0] hit, en;
  logic [XLEN:0] acc_end;
  logic commit, exc_q, stat_wr;

  assign acc_end = {1'b0, dacc_addr} + (XLEN+1)'((1 << dacc_size) - 1);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [1:0] kind, lcode;
    logic [XLEN-1:0] lmask, base;
    logic ovl;
    assign kind  = ctrl_q[KIND_LSB + 4*g +: 2];
    assign lcode = ctrl_q[LEN_LSB + 4*g +: 2];
    assign en[g] = |ctrl_q[2*g +: 2];
    assign lmask = (lcode == 2'd0) ? XLEN'(0) :
                   (lcode == 2'd1) ? XLEN'(1) :
                   (lcode == 2'd2) ? XLEN'(7) : XLEN'(3);
    assign base  = addr_q[g] & ~lmask;
    assign ovl   = ({1'b0, base} <= acc_end) && (dacc_addr <= (base | lmask));
    always_comb begin
      unique case (kind)
        2'b00:   hit[g] = ip_valid && (addr_q[g] == ip);
        2'b01:   hit[g] = dacc_valid && dacc_write && ovl;
        2'b11:   hit[g] = dacc_valid && ovl;
        default: hit[g] = 1'b0;
      endcase
    end
  end

  assign commit  = (|(hit & en)) || step_req;
  assign stat_wr = reg_we && (reg_sel == SEL_STAT);

  always_comb begin
    stat_nxt = {stat_q[XLEN-1:NSLOT], hit};
    if (step_req) stat_nxt[STEP_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) addr_q[i] <= '0;
      stat_q <= '0;
      ctrl_q <= FIX_ONES;
      exc_q  <= 1'b0;
    end else begin
      exc_q <= commit;
      if (reg_we && reg_sel < 3'(NSLOT)) addr_q[reg_sel[1:0]] <= reg_wdata;
      if (reg_we && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata | FIX_ONES;
      if (stat_wr) stat_q <= reg_wdata;
      else if (commit) stat_q <= stat_nxt;
    end
  end

  assign dbg_exc = exc_q;

  always_comb begin
    case (reg_sel)
      3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = addr_q[reg_sel[1:0]];
      SEL_STAT: reg_rdata = stat_q;
      SEL_CTRL: reg_rdata = ctrl_q;
      default:  reg_rdata = '0;
    endcase
  end

  AST_CTRL_FIXED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_sel == SEL_CTRL |=> ctrl_q == ($past(reg_wdata) | FIX_ONES)); // R2
  AST_STAT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr && !ip_valid && !dacc_valid && !step_req |=> $stable(stat_q)); // R8
  AST_STEP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    step_req && !stat_wr |=> stat_q[STEP_BIT] && dbg_exc); // R9
  AST_NO_EXC_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ip_valid && !dacc_valid && !step_req |=> !dbg_exc); // R10
  AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc && !$past(stat_wr) |-> (|stat_q[NSLOT-1:0]) || stat_q[STEP_BIT]); // R7
endmodule

// File: tb/tb_dbg_match_unit.sv
module tb_dbg_match_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, ip_valid = 0, dacc_valid = 0, dacc_write = 0, step_req = 0;
  logic [2:0] reg_sel = 0;
  logic [XLEN-1:0] reg_wdata = 0, ip = 0, dacc_addr = 0, reg_rdata;
  logic [1:0] dacc_size = 0;
  logic dbg_exc;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_addr [4];
  logic [31:0] m_stat, m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_match_unit #(.XLEN(XLEN)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (s < 4) m_addr[s[1:0]] = d;
    else if (s == 4) m_stat = d;
    else if (s == 5) m_ctrl = d | 32'h400;
  endtask

  task automatic rd(string tag, logic [2:0] s, logic [31:0] exp);
    @(negedge clk);
    reg_sel = s; #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [3:0] mhits(logic iv, logic [31:0] ipv, logic dv, logic dw,
                                       logic [31:0] da, logic [1:0] ds);
    logic [3:0] h = '0;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] k = m_ctrl[16+4*i +: 2];
      logic [1:0] lc = m_ctrl[18+4*i +: 2];
      longint len = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 2) ? 8 : 4;
      longint s = longint'(m_addr[i]) & ~(len - 1);
      longint e = s + len - 1;
      longint as = longint'(da);
      longint ae = as + (longint'(1) << ds) - 1;
      logic ov = (as <= e) && (s <= ae);
      if (k == 0) h[i] = iv && (m_addr[i] == ipv);
      else if (k == 1) h[i] = dv && dw && ov;
      else if (k == 3) h[i] = dv && ov;
    end
    return h;
  endfunction

  task automatic chk_cycle(string tag, logic iv, logic [31:0] ipv, logic dv, logic dw,
                           logic [31:0] da, logic [1:0] ds, logic st);
    logic [3:0] h, en;
    logic ex;
    h = mhits(iv, ipv, dv, dw, da, ds);
    for (int i = 0; i < 4; i++) en[i] = m_ctrl[2*i] | m_ctrl[2*i+1];
    ex = (|(h & en)) || st;
    if (ex) begin
      m_stat[3:0] = h;
      if (st) m_stat[14] = 1'b1;
    end
    @(negedge clk);
    reg_sel = 3'd4; ip_valid = iv; ip = ipv; dacc_valid = dv; dacc_write = dw;
    dacc_addr = da; dacc_size = ds; step_req = st;
    @(negedge clk);
    ip_valid = 0; dacc_valid = 0; step_req = 0;
    #1;
    chk({tag, " exc"}, 32'(dbg_exc), 32'(ex));
    chk({tag, " status"}, reg_rdata, m_stat);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none
  end

  initial begin
    for (int i = 0; i < 4; i++) m_addr[i] = 0;
    m_stat = 0; m_ctrl = 32'h400;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd("R1 addr0", 3'd0, 0);
    rd("R1 addr3", 3'd3, 0);
    rd("R1 status", 3'd4, 0);
    rd("R1 control", 3'd5, 32'h400);
    // R2 register port
    wr(3'd5, 32'h0000_0001);
    rd("R2 control fixed one", 3'd5, 32'h0000_0401);
    wr(3'd2, 32'hDEAD_BEEF);
    rd("R2 addr2", 3'd2, 32'hDEAD_BEEF);
    wr(3'd4, 32'h0000_A000);
    rd("R2 status", 3'd4, 32'h0000_A000);
    wr(3'd7, 32'hFFFF_FFFF);
    rd("R2 unused select", 3'd7, 0);
    rd("R2 unused no side effect", 3'd5, 32'h0000_0401);
    // R4 R7 disabled slot still flagged: slot0 enabled, slot1 disabled, both exec at 0x100
    wr(3'd0, 32'h100); wr(3'd1, 32'h100);
    wr(3'd5, 32'h0000_0001);
    chk_cycle("R7 disabled slot flagged", 1, 32'h100, 0, 0, 0, 0, 0);
    // R3 R8 only disabled slot matches
    wr(3'd0, 32'h200);
    wr(3'd4, 32'h0000_0000);
    chk_cycle("R8 disabled only", 1, 32'h100, 0, 0, 0, 0, 0);
    // R3 global enable bit alone
    wr(3'd5, 32'h0000_0008);
    chk_cycle("R3 global enable", 1, 32'h100, 0, 0, 0, 0, 0);
    // R5 write-kind slot0, 8-byte length (code 2) at 0x1003 -> 0x1000..0x1007
    wr(3'd0, 32'h1003);
    wr(3'd5, 32'h0009_0001);
    chk_cycle("R5 write kind ignores read", 0, 0, 1, 0, 32'h1004, 0, 0);
    chk_cycle("R6 len8 upper byte", 0, 0, 1, 1, 32'h1007, 0, 0);
    chk_cycle("R6 len8 past end", 0, 0, 1, 1, 32'h1008, 0, 0);
    chk_cycle("R6 access spans in", 0, 0, 1, 1, 32'h0FFE, 2, 0);
    // R6 length code 3 -> 4 bytes
    wr(3'd0, 32'h1006);
    wr(3'd5, 32'h000F_0001);
    chk_cycle("R6 len4 base", 0, 0, 1, 0, 32'h1004, 0, 0);
    chk_cycle("R6 len4 beyond", 0, 0, 1, 0, 32'h1008, 3, 0);
    // R5 I/O kind never matches
    wr(3'd5, 32'h000E_0001);
    chk_cycle("R5 io kind", 0, 0, 1, 1, 32'h1004, 3, 0);
    // R9 step request
    chk_cycle("R9 step", 0, 0, 0, 0, 0, 0, 1);
    // R10 pulse lasts one cycle
    @(negedge clk);
    chk("R10 pulse ends", 32'(dbg_exc), 0);
    // random
    for (int it = 0; it < 400; it++) begin
      logic [31:0] r;
      if (it % 16 == 0) begin
        for (int s = 0; s < 4; s++) wr(3'(s), 32'h1000 + ($urandom % 64));
        wr(3'd5, $urandom);
        if ($urandom % 4 == 0) wr(3'd4, $urandom & 32'hFFFF_BFF0);
      end
      r = $urandom;
      chk_cycle("R7 random", r[0], 32'h1000 + ($urandom % 64), r[1], r[2],
                32'h1000 + ($urandom % 72), r[4:3], (r[7:5] == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
  end
endmodule